// File: doc/BRIEF.md
# Serial register bridge command engine

This block bridges a memory-mapped host register bus to a remote register slave. Remote reads are command driven: the host writes a slave register offset into a read-command register, and that write alone launches the transfer. The host then polls a read-data register. Bit 31 of that register is a busy flag. When busy drops, the lower half holds the 16-bit value and the bits between hold a 15-bit echo of the requested address, so software can confirm that the value belongs to its request.

Remote writes go through an address window placed at a fixed distance from the block's base. Each bus write that lands in the window is queued in a small write FIFO. The host can see the FIFO's full and empty flags in a status register. A single sequencer forwards queued writes and read commands to the slave over one request channel, in the order the host issued them. The address mode is a parameter. It sets the window base, the window size, the width of the slave select field and how the echo is formed.

The host request channel is valid/ready. A request is taken on a cycle where both `req_valid` and `req_ready` are high. A read request produces exactly one response on the valid/ready response channel on the following cycle. `req_ready` stays low while a response waits for `rsp_ready`, so at most one read response is ever outstanding. The slave request channel is also valid/ready and the block holds its request until the slave takes it. The slave answers a read with a one-cycle `slv_rvalid` pulse. It may do this at any later cycle.

Top module: `sbr_bridge`

## Requirements
- R1: A host write of an in-range offset (wdata bits 31:17 zero) to address 0x28 starts a slave read. No separate start bit is needed. Busy (bit 31 of the word at 0x2C) reads as 1 from the very next host access. Busy rises for no other reason.
- R2: When the slave's read response arrives, busy returns to 0. The word at 0x2C then carries the returned 16-bit value in bits 15:0 and the echo in bits 30:16.
- R3: In address mode 0, the echo equals offset bits 14:0. In modes 1 and 2, the echo equals offset bits 16:2.
- R4: Reading host address 0x30 returns the write-FIFO status: bit 11 = full, bit 10 = empty, bit 0 = overflow. All other bits are 0. Full and empty are never both 1.
- R5: A host write to base + offset, with window base 0x8000 (modes 0, 1) or 0x20000 (mode 2) and window size 4 KB / 16 KB / 128 KB (modes 0 / 1 / 2), is queued. It is then sent to the slave as a write with `slv_addr` = offset and `slv_wdata` = wdata bits 15:0.
- R6: A window write while the FIFO is full is dropped and never reaches the slave. Queued entries stay unchanged. The overflow bit is set and stays set until reset.
- R7: A read command is sent to the slave only after every write queued before it has been sent. No write is sent while a read is waiting for its response.
- R8: An offset at or beyond the window size, or one whose select field is 3 in modes 1 and 2, is ignored. This holds both for read commands (busy stays 0 and the read word is unchanged) and for window writes (nothing is queued).
- R9: A read command written while busy is 1 is ignored. The pending read completes with its own echo.
- R10: The read response appears one cycle after the read request is taken and is held, unchanged, while `rsp_ready` is low. `req_ready` is low during that time. Reads of any address other than 0x2C and 0x30 return 0.
- R11: In modes 1 and 2, `slv_sel` carries the top two bits of the window offset (bits 13:12 in mode 1, bits 16:15 in mode 2). In mode 0, `slv_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Host byte address |
| req_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes read response |
| rsp_data | output | 32 | Read response data |
| slv_valid | output | 1 | Slave request valid |
| slv_ready | input | 1 | Slave takes request |
| slv_write | output | 1 | 1 = slave write, 0 = slave read |
| slv_sel | output | 2 | Slave select |
| slv_addr | output | 17 | Window offset of the access |
| slv_wdata | output | 16 | Slave write data |
| slv_rvalid | input | 1 | Slave read response pulse |
| slv_rdata | input | 16 | Slave read value |

## Verification
The hardest state to reach from the ports combines a full write FIFO, a dropped extra write, and a read command whose target was queued last. The read must then wait for four writes ahead of it before it returns the freshly written value. The bench gets there by holding the slave's ready low to freeze the FIFO, filling it, overrunning it and issuing the read, and only then releasing the slave. The same stall is used to hold a read in flight so that a second command can be shown to be ignored. Random traffic with a randomly stalling slave and random response latency checks every read against a shadow copy of the slave, which the bench updates in issue order.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int HOST_AW   = 19;
  localparam int MAX_OFF_W = 17;
  localparam int DATA_W    = 16;

  localparam logic [HOST_AW-1:0] ADR_RDCMD  = 19'h00028;
  localparam logic [HOST_AW-1:0] ADR_RDWORD = 19'h0002C;
  localparam logic [HOST_AW-1:0] ADR_WSTAT  = 19'h00030;

  typedef struct packed {
    logic [MAX_OFF_W-1:0] off;
    logic [DATA_W-1:0]    data;
  } wr_entry_t;

  function automatic int win_base(input int mode);
    return (mode == 2) ? 32'h20000 : 32'h8000;
  endfunction

  function automatic int win_off_w(input int mode);
    return (mode == 0) ? 12 : ((mode == 1) ? 14 : 17);
  endfunction
endpackage

// File: rtl/sbr_decode.sv
module sbr_decode
  import sbr_pkg::*;
#(
  parameter int ADDR_MODE = 1
) (
  input  logic [HOST_AW-1:0]   addr,
  input  logic [31:0]          wdata,
  output logic                 hit_cmd,
  output logic                 hit_rdword,
  output logic                 hit_stat,
  output logic                 win_ok,
  output logic [MAX_OFF_W-1:0] win_off,
  output logic                 cmd_ok,
  output logic [MAX_OFF_W-1:0] cmd_off
);
  localparam int OFF_W = win_off_w(ADDR_MODE);
  localparam logic [HOST_AW:0] BASE_X = (HOST_AW+1)'(win_base(ADDR_MODE));
  localparam logic [HOST_AW:0] END_X  = BASE_X + ((HOST_AW+1)'(1) << OFF_W);

  function automatic logic off_valid(input logic [MAX_OFF_W-1:0] o);
    logic in_range;
    logic sel_ok;
    in_range = ((o >> OFF_W) == '0);
    if (ADDR_MODE == 0) sel_ok = 1'b1;
    else                sel_ok = (o[OFF_W-1 -: 2] != 2'b11);
    return in_range && sel_ok;
  endfunction

  logic [HOST_AW:0] addr_x;
  logic             in_win;

  always_comb begin
    addr_x     = {1'b0, addr};
    hit_cmd    = (addr == ADR_RDCMD);
    hit_rdword = (addr == ADR_RDWORD);
    hit_stat   = (addr == ADR_WSTAT);
    in_win     = (addr_x >= BASE_X) && (addr_x < END_X);
    win_off    = MAX_OFF_W'(addr_x - BASE_X);
    win_ok     = in_win && off_valid(win_off);
    cmd_off    = wdata[MAX_OFF_W-1:0];
    cmd_ok     = (wdata[31:MAX_OFF_W] == '0) && off_valid(cmd_off);
  end
endmodule

// File: rtl/sbr_wfifo.sv
module sbr_wfifo #(
  parameter int W     = 33,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (push && !pop)      cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign count = cnt;
endmodule

// File: rtl/sbr_engine.sv
module sbr_engine
  import sbr_pkg::*;
#(
  parameter int ADDR_MODE = 1,
  parameter int CW        = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_fire,
  input  logic [MAX_OFF_W-1:0] cmd_off,
  input  logic [CW-1:0]        fifo_count,
  input  logic                 fifo_empty,
  input  wr_entry_t            fifo_head,
  output logic                 fifo_pop,
  output logic                 slv_valid,
  input  logic                 slv_ready,
  output logic                 slv_write,
  output logic [MAX_OFF_W-1:0] slv_off,
  output logic [DATA_W-1:0]    slv_wdata,
  input  logic                 slv_rvalid,
  input  logic [DATA_W-1:0]    slv_rdata,
  output logic                 busy,
  output logic                 rd_out,
  output logic [31:0]          rd_word
);
  logic                 rd_pend;
  logic [CW-1:0]        ahead;
  logic [MAX_OFF_W-1:0] rd_off;
  logic [DATA_W-1:0]    rd_val;
  logic [14:0]          echo_q;
  logic [14:0]          echo_new;
  logic                 issue_rd;
  logic                 wr_ok;

  generate
    if (ADDR_MODE == 0) begin : g_echo_narrow
      assign echo_new = rd_off[14:0];
    end else begin : g_echo_wide
      assign echo_new = rd_off[16:2];
    end
  endgenerate

  always_comb begin
    issue_rd  = rd_pend && (ahead == '0) && !rd_out;
    wr_ok     = !fifo_empty && !(rd_pend && (ahead == '0));
    slv_valid = issue_rd || wr_ok;
    slv_write = !issue_rd;
    slv_off   = issue_rd ? rd_off : fifo_head.off;
    slv_wdata = fifo_head.data;
    fifo_pop  = wr_ok && slv_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_out  <= 1'b0;
      ahead   <= '0;
      rd_off  <= '0;
      rd_val  <= '0;
      echo_q  <= '0;
    end else begin
      if (cmd_fire) begin
        rd_pend <= 1'b1;
        rd_off  <= cmd_off;
        ahead   <= fifo_count - CW'(fifo_pop);
      end else if (rd_pend && fifo_pop) begin
        ahead <= ahead - CW'(1);
      end
      if (issue_rd && slv_ready) rd_out <= 1'b1;
      if (rd_out && slv_rvalid) begin
        rd_out  <= 1'b0;
        rd_pend <= 1'b0;
        rd_val  <= slv_rdata;
        echo_q  <= echo_new;
      end
    end
  end

  assign busy    = rd_pend;
  assign rd_word = {rd_pend, echo_q, rd_val};
endmodule

// File: rtl/sbr_bridge.sv
module sbr_bridge
  import sbr_pkg::*;
#(
  parameter int ADDR_MODE  = 1,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [HOST_AW-1:0]   req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [31:0]          rsp_data,
  output logic                 slv_valid,
  input  logic                 slv_ready,
  output logic                 slv_write,
  output logic [1:0]           slv_sel,
  output logic [MAX_OFF_W-1:0] slv_addr,
  output logic [DATA_W-1:0]    slv_wdata,
  input  logic                 slv_rvalid,
  input  logic [DATA_W-1:0]    slv_rdata
);
  localparam int OFF_W = win_off_w(ADDR_MODE);
  localparam int CW    = $clog2(FIFO_DEPTH + 1);

  logic                 hit_cmd, hit_rdword, hit_stat, win_ok, cmd_ok;
  logic [MAX_OFF_W-1:0] win_off, cmd_off, eng_off;
  logic                 take, wr_take, rd_take;
  logic                 fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [CW-1:0]        fifo_cnt;
  wr_entry_t            fifo_in, fifo_head;
  logic                 cmd_fire, busy, rd_out;
  logic [31:0]          rd_word;
  logic                 ovf_q, rsp_v_q;
  logic [31:0]          rsp_q, rd_mux;

  sbr_decode #(.ADDR_MODE(ADDR_MODE)) u_dec (
    .addr(req_addr), .wdata(req_wdata),
    .hit_cmd(hit_cmd), .hit_rdword(hit_rdword), .hit_stat(hit_stat),
    .win_ok(win_ok), .win_off(win_off), .cmd_ok(cmd_ok), .cmd_off(cmd_off)
  );

  assign req_ready = !rsp_v_q;
  assign take      = req_valid && req_ready;
  assign wr_take   = take && req_write;
  assign rd_take   = take && !req_write;
  assign fifo_push = wr_take && win_ok && !fifo_full;
  assign cmd_fire  = wr_take && hit_cmd && cmd_ok && !busy;

  always_comb begin
    fifo_in      = '0;
    fifo_in.off  = win_off;
    fifo_in.data = req_wdata[DATA_W-1:0];
  end

  sbr_wfifo #(.W($bits(wr_entry_t)), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(fifo_push), .din(fifo_in),
    .pop(fifo_pop), .dout(fifo_head),
    .full(fifo_full), .empty(fifo_empty), .count(fifo_cnt)
  );

  sbr_engine #(.ADDR_MODE(ADDR_MODE), .CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .cmd_fire(cmd_fire), .cmd_off(cmd_off),
    .fifo_count(fifo_cnt), .fifo_empty(fifo_empty), .fifo_head(fifo_head),
    .fifo_pop(fifo_pop),
    .slv_valid(slv_valid), .slv_ready(slv_ready), .slv_write(slv_write),
    .slv_off(eng_off), .slv_wdata(slv_wdata),
    .slv_rvalid(slv_rvalid), .slv_rdata(slv_rdata),
    .busy(busy), .rd_out(rd_out), .rd_word(rd_word)
  );

  assign slv_addr = eng_off;
  generate
    if (ADDR_MODE == 0) begin : g_single_slave
      assign slv_sel = 2'b00;
    end else begin : g_multi_slave
      assign slv_sel = eng_off[OFF_W-1 -: 2];
    end
  endgenerate

  always_comb begin
    if (hit_rdword)    rd_mux = rd_word;
    else if (hit_stat) rd_mux = {20'b0, fifo_full, fifo_empty, 9'b0, ovf_q};
    else               rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q   <= 1'b0;
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      if (wr_take && win_ok && fifo_full) ovf_q <= 1'b1;
      if (rd_take) begin
        rsp_v_q <= 1'b1;
        rsp_q   <= rd_mux;
      end else if (rsp_ready) begin
        rsp_v_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_q;
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker
  import sbr_pkg::*;
#(
  parameter int ADDR_MODE = 1,
  parameter int CW        = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [HOST_AW-1:0] req_addr,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [31:0]        rsp_data,
  input logic               slv_valid,
  input logic               slv_write,
  input logic [1:0]         slv_sel,
  input logic               slv_rvalid,
  input logic               busy,
  input logic               rd_out,
  input logic               win_ok,
  input logic               fifo_full,
  input logic               fifo_empty,
  input logic [CW-1:0]      fifo_cnt,
  input logic               ovf
);
  assert_busy_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready && req_write && req_addr == ADR_RDCMD));

  assert_busy_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out && slv_rvalid) |=> !busy);

  assert_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && win_ok && fifo_full)
      |=> (ovf && fifo_cnt <= $past(fifo_cnt)));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf) |-> ovf);

  assert_read_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out |-> !(slv_valid && slv_write));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_ready_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    slv_valid |-> ((ADDR_MODE == 0) ? (slv_sel == 2'b00) : (slv_sel != 2'b11)));
endmodule

bind sbr_bridge sbr_checker #(.ADDR_MODE(ADDR_MODE), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .slv_valid(slv_valid), .slv_write(slv_write), .slv_sel(slv_sel),
  .slv_rvalid(slv_rvalid),
  .busy(busy), .rd_out(rd_out), .win_ok(win_ok),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_cnt(fifo_cnt),
  .ovf(ovf_q)
);

// File: tb/sbr_bridge_tb_top.sv
`timescale 1ns/1ps
module sbr_bridge_tb_top;
  localparam logic [18:0] WBASE = 19'h08000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        slv_valid, slv_write, slv_rvalid;
  logic        slv_ready = 1'b0;
  logic [1:0]  slv_sel;
  logic [16:0] slv_addr;
  logic [15:0] slv_wdata, slv_rdata;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  stall = 1'b0;

  always #2.5 clk = ~clk;

  sbr_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .slv_valid(slv_valid), .slv_ready(slv_ready), .slv_write(slv_write),
    .slv_sel(slv_sel), .slv_addr(slv_addr), .slv_wdata(slv_wdata),
    .slv_rvalid(slv_rvalid), .slv_rdata(slv_rdata)
  );

  // Behavioural slave: 256-word store indexed by {select, offset[7:2]}
  logic [15:0] smem [256];
  bit          pend;
  int          lat;
  logic [15:0] pdata;

  function automatic logic [15:0] init_val(input int i);
    return 16'(i * 16'h0101) ^ 16'h5A5A;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) smem[i] <= init_val(i);
      pend <= 1'b0; lat <= 0; slv_rvalid <= 1'b0; slv_rdata <= '0; pdata <= '0;
    end else begin
      slv_rvalid <= 1'b0;
      if (pend) begin
        if (lat == 0) begin
          slv_rvalid <= 1'b1; slv_rdata <= pdata; pend <= 1'b0;
        end else lat <= lat - 1;
      end
      if (slv_valid && slv_ready) begin
        if (slv_write) smem[{slv_sel, slv_addr[7:2]}] <= slv_wdata;
        else begin
          pend <= 1'b1; lat <= int'($urandom % 3); pdata <= smem[{slv_sel, slv_addr[7:2]}];
        end
      end
    end
  end

  always @(negedge clk) slv_ready = stall ? 1'b0 : (($urandom % 4) != 0);

  // Bench reference
  logic [15:0] shadow [256];
  function automatic logic [7:0] idx(input logic [16:0] off);
    return {off[13:12], off[7:2]};
  endfunction
  function automatic logic [31:0] exp_word(input logic [16:0] off);
    return {1'b0, off[16:2], shadow[idx(off)]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input logic [18:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    r = '0;
    if (!wr) begin
      @(negedge clk);
      while (!rsp_valid) @(negedge clk);
      r = rsp_data;
    end
  endtask

  task automatic host_wr(input logic [18:0] a, input logic [31:0] d);
    logic [31:0] unused;
    bus(1'b1, a, d, unused);
  endtask

  task automatic host_rd(input logic [18:0] a, output logic [31:0] r);
    bus(1'b0, a, '0, r);
  endtask

  task automatic wait_idle(output logic [31:0] r);
    for (int i = 0; i < 500; i++) begin
      host_rd(19'h2C, r);
      if (!r[31]) return;
    end
    chk("R2 busy never cleared", r[31], 32'd0);
  endtask

  task automatic wait_empty();
    logic [31:0] s;
    for (int i = 0; i < 500; i++) begin
      host_rd(19'h30, s);
      if (s[10]) return;
    end
    chk("R5 fifo never drained", s[10], 32'd1);
  endtask

  task automatic win_write(input logic [16:0] off, input logic [15:0] d);
    logic [31:0] s;
    for (int i = 0; i < 500; i++) begin
      host_rd(19'h30, s);
      if (!s[11]) break;
    end
    host_wr(WBASE + 19'(off), {16'hA5A5, d});
    shadow[idx(off)] = d;
  endtask

  task automatic read_check(input string tag, input logic [16:0] off);
    logic [31:0] r;
    logic [31:0] e;
    e = exp_word(off);
    host_wr(19'h28, {15'b0, off});
    wait_idle(r);
    chk(tag, r, e);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r, prev;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) shadow[i] = init_val(i);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // Reset state
    host_rd(19'h30, r); chk("R4 reset status", r, 32'h0000_0400);
    host_rd(19'h2C, r); chk("R2 reset read word", r, 32'h0);
    host_rd(19'h0100, r); chk("R10 unmapped read", r, 32'h0);

    // R1: busy visible immediately, read completes with data and echo (R2, R3, R11)
    stall = 1'b1;
    host_wr(19'h28, 32'h0000_1024);
    host_rd(19'h2C, r); chk("R1 busy set", {31'b0, r[31]}, 32'd1);
    stall = 1'b0;
    wait_idle(r); chk("R2 R3 R11 first read", r, exp_word(17'h1024));

    // R9: second command while busy is ignored
    stall = 1'b1;
    host_wr(19'h28, 32'h0000_0100);
    host_wr(19'h28, 32'h0000_0200);
    stall = 1'b0;
    wait_idle(r); chk("R9 ignored while busy", r, exp_word(17'h0100));
    prev = r;

    // R8: out-of-range and select-3 commands ignored
    host_wr(19'h28, 32'h0000_4000);
    host_rd(19'h2C, r); chk("R8 beyond window cmd", r, prev);
    host_wr(19'h28, 32'h0000_3004);
    host_rd(19'h2C, r); chk("R8 select 3 cmd", r, prev);
    host_wr(19'h28, 32'h0002_0000);
    host_rd(19'h2C, r); chk("R8 high bits cmd", r, prev);
    wait_empty();
    stall = 1'b1;
    host_wr(WBASE + 19'h4000, 32'h1111);
    host_wr(WBASE + 19'h3000, 32'h2222);
    host_rd(19'h30, r); chk("R8 window writes ignored", r, 32'h0000_0400);
    stall = 1'b0;

    // R10: response held under back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h30;
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk("R10 rsp valid", {31'b0, rsp_valid}, 32'd1);
    chk("R10 req_ready low", {31'b0, req_ready}, 32'd0);
    prev = rsp_data;
    @(negedge clk);
    chk("R10 rsp held", {31'b0, rsp_valid}, 32'd1);
    chk("R10 rsp stable", rsp_data, prev);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 rsp released", {31'b0, rsp_valid}, 32'd0);

    // R4 R6 R7: fill, overrun, read behind queued writes
    wait_empty();
    stall = 1'b1;
    win_write(17'h0010, 16'h1001);
    win_write(17'h1020, 16'h2002);
    win_write(17'h2030, 16'h3003);
    win_write(17'h0040, 16'h4004);
    host_rd(19'h30, r); chk("R4 full status", r, 32'h0000_0800);
    host_wr(WBASE + 19'h0050, 32'h0000_DEAD);
    host_rd(19'h30, r); chk("R6 overflow flag", r, 32'h0000_0801);
    host_wr(19'h28, 32'h0000_0040);
    host_rd(19'h2C, r); chk("R1 busy behind queue", {31'b0, r[31]}, 32'd1);
    stall = 1'b0;
    wait_idle(r); chk("R7 read after queued writes", r, exp_word(17'h0040));
    read_check("R6 dropped write absent", 17'h0050);
    read_check("R5 queued write select 1", 17'h1020);
    read_check("R5 queued write select 2", 17'h2030);
    wait_empty();
    host_rd(19'h30, r); chk("R6 overflow sticky", r, 32'h0000_0401);

    // Random traffic, reads checked against shadow (R2 R3 R5 R7 R11)
    for (int n = 0; n < 80; n++) begin
      logic [16:0] off;
      off = 17'(($urandom % 32'h3000) & 32'hFFFC);
      if ($urandom % 2 == 0) win_write(off, 16'($urandom));
      else read_check("R7 R3 random read", off);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule